// File: doc/BRIEF.md
# Trap Instruction Value Generator

This block produces the word that a trap handler finds in the trap-instruction register when a trap is taken into hypervisor-supervisor mode or machine mode. When a trap is raised, the pipeline presents the faulting instruction, a flag marking it as a 16-bit compressed encoding, its access class, the exception cause, and a description of any implicit guest page-table access that caused the fault. One cycle later the block returns a single 32-bit value. That value is one of three kinds: zero, a normalized copy of the faulting load, store, atomic or hypervisor memory instruction, or a fixed code for an implicit page-table read or write.

A normalized instruction keeps only the fields a handler needs to emulate the access: the opcode, the width and type selector, and the data register. The base register is cleared, and for loads and stores the offset is cleared as well. The two lowest bits record whether the original encoding was compressed (`01`) or full size (`11`). A compressed load or store is first expanded to its full-size equivalent. The expansion follows RV64 by default, and an RV32 variant is selected by parameter.

For a guest-page fault raised while walking the guest page table, where a nonzero guest physical address is also being reported, the block returns a pseudo-code whose low two bits are zero. The code states the width of the table entry and whether the access was a read or an accessed/dirty-bit update.

Top module: `tinst_gen`

## Requirements
- R1: After reset, `tinstValid` is 0 and `tinstValue` is 0. `tinstValid` is 1 in exactly the cycle after each cycle with `trapValid` = 1, and 0 otherwise. `tinstValue` updates only on a captured trap and holds its value otherwise.
- R2: A cause code outside {4, 5, 6, 7, 13, 15, 21, 23} yields 0. This covers load/store misaligned, access, page and guest-page faults only.
- R3: A full-size trap with class 1 (load) yields `{17'b0, instr[14:12], instr[11:7], instr[6:2], 2'b11}`.
- R4: A full-size trap with class 2 (store) yields `{7'b0, instr[24:20], 5'b0, instr[14:12], 5'b0, instr[6:2], 2'b11}`.
- R5: A full-size trap with class 3 (atomic) or class 4 (hypervisor load/store) yields the instruction with bits 19:15 cleared and bits 1:0 set to `11`.
- R6: A compressed trap with class 1 or 2 whose encoding is a compressed load (quadrant 0 or 2, bits 15:13 = 001, 010 or 011) yields `{17'b0, f3, rd, op[6:2], 2'b01}`. The mapping is 001→(0000111, 011), 010→(0000011, 010) and 011→(0000011, 011). In quadrant 0, rd is `{2'b01, c[4:2]}`; in quadrant 2, rd is `c[11:7]`.
- R7: A compressed store encoding (bits 15:13 = 101, 110 or 111) yields `{7'b0, rs2, 5'b0, f3, 5'b0, op[6:2], 2'b01}`. The mapping is 101→(0100111, 011), 110→(0100011, 010) and 111→(0100011, 011). In quadrant 0, rs2 is `{2'b01, c[4:2]}`; in quadrant 2, rs2 is `c[6:2]`.
- R8: Any of the following yields 0: class 0; a compressed trap with class 3 or 4; or a compressed encoding in quadrant 1 or with bits 15:13 of 000 or 100.
- R9: When `implicitWalk` = 1, the cause is 21 or 23, and `gpaNonzero` = 1, the output is nonzero. It equals 0x00002000, plus 0x00001000 if `walkIs64`, plus 0x00000020 if `walkIsWrite`.
- R10: When `implicitWalk` = 1 without both a guest-page cause and `gpaNonzero`, the output is 0.
- R11: When `implicitWalk` = 1, the instruction bits, class and compressed flag have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapValid | input | 1 | Trap presented this cycle |
| instrBits | input | 32 | Faulting instruction; bits 15:0 when compressed |
| isCompressed | input | 1 | Instruction is a 16-bit encoding |
| instrClass | input | 3 | 0 none, 1 load, 2 store, 3 atomic, 4 hypervisor load/store |
| causeCode | input | 6 | Exception cause code |
| implicitWalk | input | 1 | Fault came from an implicit guest page-table access |
| walkIs64 | input | 1 | Page-table entry is 64 bits wide |
| walkIsWrite | input | 1 | Implicit access updates accessed/dirty bits |
| gpaNonzero | input | 1 | A nonzero guest physical address is being reported |
| tinstValid | output | 1 | Result valid, one cycle after the trap |
| tinstValue | output | 32 | Trap instruction value |

## Verification
The assertions assume that `trapValid` is a clean, known level and that the class and cause inputs are known whenever a trap is presented. They do not assume that the class agrees with the instruction bits, because the block trusts the class input.

The stimulus runs directed cases for every compressed selector, both quadrants, and all four pseudo-codes. It then mixes in random traps with random gaps. During those gaps the remaining inputs still toggle, to show that the result register holds. Random full-size words always carry `11` in their low bits, and random compressed words keep the upper half random to show that it is ignored.

// File: rtl/tinst_pkg.sv
package tinst_pkg;
  localparam int unsigned WordW  = 32;
  localparam int unsigned HalfW  = WordW / 2;
  localparam int unsigned CauseW = 6;
  localparam int unsigned ClassW = 3;

  typedef enum logic [ClassW-1:0] {
    ClsNone   = 3'd0,
    ClsLoad   = 3'd1,
    ClsStore  = 3'd2,
    ClsAtomic = 3'd3,
    ClsHypLs  = 3'd4
  } instClassT;

  typedef struct packed {
    logic capture;
    logic selPseudo;
    logic selXform;
  } tinstStrobeT;

  localparam logic [CauseW-1:0] CauseLdMisal  = 6'd4;
  localparam logic [CauseW-1:0] CauseLdAccess = 6'd5;
  localparam logic [CauseW-1:0] CauseStMisal  = 6'd6;
  localparam logic [CauseW-1:0] CauseStAccess = 6'd7;
  localparam logic [CauseW-1:0] CauseLdPage   = 6'd13;
  localparam logic [CauseW-1:0] CauseStPage   = 6'd15;
  localparam logic [CauseW-1:0] CauseLdGuest  = 6'd21;
  localparam logic [CauseW-1:0] CauseStGuest  = 6'd23;

  localparam logic [6:0] OpLoad    = 7'b0000011;
  localparam logic [6:0] OpLoadFp  = 7'b0000111;
  localparam logic [6:0] OpStore   = 7'b0100011;
  localparam logic [6:0] OpStoreFp = 7'b0100111;

  localparam logic [WordW-1:0] PseudoBase  = WordW'(32'h0000_2000);
  localparam logic [WordW-1:0] PseudoWide  = WordW'(32'h0000_1000);
  localparam logic [WordW-1:0] PseudoWrite = WordW'(32'h0000_0020);
endpackage

// File: rtl/tinst_rvc_expand.sv
module tinst_rvc_expand
  import tinst_pkg::*;
#(
  parameter int unsigned Xlen = 64
) (
  input  logic [HalfW-1:0] half,
  output logic             hit,
  output logic             isStore,
  output logic [6:0]       opcode,
  output logic [2:0]       funct3,
  output logic [4:0]       regIdx
);
  logic [1:0] quad;
  logic [2:0] sel;
  logic       quadOk;
  logic [6:0] pairLdOp, pairStOp;
  logic [2:0] pairF3;
  logic       unusedBits;

  assign quad       = half[1:0];
  assign sel        = half[15:13];
  assign quadOk     = (quad == 2'b00) || (quad == 2'b10);
  assign unusedBits = half[12];

  // Selector 011/111 means double-word integer on RV64, single float on RV32
  generate
    if (Xlen == 64) begin : g_rv64
      assign pairLdOp = OpLoad;
      assign pairStOp = OpStore;
      assign pairF3   = 3'b011;
    end else begin : g_rv32
      assign pairLdOp = OpLoadFp;
      assign pairStOp = OpStoreFp;
      assign pairF3   = 3'b010;
    end
  endgenerate

  always_comb begin
    hit     = quadOk;
    isStore = sel[2];
    opcode  = OpLoad;
    funct3  = 3'b000;
    case (sel)
      3'b001: begin opcode = OpLoadFp;  funct3 = 3'b011; end
      3'b010: begin opcode = OpLoad;    funct3 = 3'b010; end
      3'b011: begin opcode = pairLdOp;  funct3 = pairF3; end
      3'b101: begin opcode = OpStoreFp; funct3 = 3'b011; end
      3'b110: begin opcode = OpStore;   funct3 = 3'b010; end
      3'b111: begin opcode = pairStOp;  funct3 = pairF3; end
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    if (quad == 2'b00)  regIdx = {2'b01, half[4:2]};
    else if (isStore)   regIdx = half[6:2];
    else                regIdx = half[11:7];
  end
endmodule

// File: rtl/tinst_ctrl.sv
module tinst_ctrl
  import tinst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapValid,
  input  logic [ClassW-1:0] instrClass,
  input  logic [CauseW-1:0] causeCode,
  input  logic              isCompressed,
  input  logic              implicitWalk,
  input  logic              gpaNonzero,
  output tinstStrobeT       strb,
  output logic              tinstValid
);
  logic causeCovered;
  logic causeGuest;

  always_comb begin
    case (causeCode)
      CauseLdMisal, CauseLdAccess, CauseStMisal, CauseStAccess,
      CauseLdPage, CauseStPage, CauseLdGuest, CauseStGuest: causeCovered = 1'b1;
      default: causeCovered = 1'b0;
    endcase
    causeGuest = (causeCode == CauseLdGuest) || (causeCode == CauseStGuest);
  end

  always_comb begin
    strb         = '0;
    strb.capture = trapValid;
    if (causeCovered) begin
      if (implicitWalk) begin
        strb.selPseudo = causeGuest && gpaNonzero;
      end else begin
        case (instrClass)
          ClsLoad, ClsStore:   strb.selXform = 1'b1;
          ClsAtomic, ClsHypLs: strb.selXform = !isCompressed;
          default:             strb.selXform = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) tinstValid <= 1'b0;
    else       tinstValid <= trapValid;
  end
endmodule

// File: rtl/tinst_datapath.sv
module tinst_datapath
  import tinst_pkg::*;
#(
  parameter int unsigned Xlen = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  tinstStrobeT       strb,
  input  logic [WordW-1:0]  instrBits,
  input  logic              isCompressed,
  input  logic [ClassW-1:0] instrClass,
  input  logic              walkIs64,
  input  logic              walkIsWrite,
  output logic [WordW-1:0]  tinstValue
);
  logic             expHit, expIsStore;
  logic [6:0]       expOpcode;
  logic [2:0]       expFunct3;
  logic [4:0]       expReg;
  logic [WordW-1:0] xformWord, pseudoWord, nextValue;

  tinst_rvc_expand #(.Xlen(Xlen)) u_expand (
    .half    (instrBits[HalfW-1:0]),
    .hit     (expHit),
    .isStore (expIsStore),
    .opcode  (expOpcode),
    .funct3  (expFunct3),
    .regIdx  (expReg)
  );

  always_comb begin
    if (isCompressed) begin
      if (!expHit)
        xformWord = '0;
      else if (expIsStore)
        xformWord = {7'b0, expReg, 5'b0, expFunct3, 5'b0, expOpcode[6:2], 2'b01};
      else
        xformWord = {17'b0, expFunct3, expReg, expOpcode[6:2], 2'b01};
    end else begin
      case (instrClass)
        ClsLoad:  xformWord = {17'b0, instrBits[14:12], instrBits[11:7], instrBits[6:2], 2'b11};
        ClsStore: xformWord = {7'b0, instrBits[24:20], 5'b0, instrBits[14:12], 5'b0,
                               instrBits[6:2], 2'b11};
        default:  xformWord = {instrBits[31:20], 5'b0, instrBits[14:2], 2'b11};
      endcase
    end
  end

  always_comb begin
    pseudoWord = PseudoBase;
    if (walkIs64)    pseudoWord = pseudoWord | PseudoWide;
    if (walkIsWrite) pseudoWord = pseudoWord | PseudoWrite;
  end

  always_comb begin
    if (strb.selPseudo)     nextValue = pseudoWord;
    else if (strb.selXform) nextValue = xformWord;
    else                    nextValue = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             tinstValue <= '0;
    else if (strb.capture) tinstValue <= nextValue;
  end
endmodule

// File: rtl/tinst_gen.sv
module tinst_gen
  import tinst_pkg::*;
#(
  parameter int unsigned Xlen = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        trapValid,
  input  logic [31:0] instrBits,
  input  logic        isCompressed,
  input  logic [2:0]  instrClass,
  input  logic [5:0]  causeCode,
  input  logic        implicitWalk,
  input  logic        walkIs64,
  input  logic        walkIsWrite,
  input  logic        gpaNonzero,
  output logic        tinstValid,
  output logic [31:0] tinstValue
);
  tinstStrobeT strb;

  tinst_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .trapValid    (trapValid),
    .instrClass   (instrClass),
    .causeCode    (causeCode),
    .isCompressed (isCompressed),
    .implicitWalk (implicitWalk),
    .gpaNonzero   (gpaNonzero),
    .strb         (strb),
    .tinstValid   (tinstValid)
  );

  tinst_datapath #(.Xlen(Xlen)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .instrBits    (instrBits),
    .isCompressed (isCompressed),
    .instrClass   (instrClass),
    .walkIs64     (walkIs64),
    .walkIsWrite  (walkIsWrite),
    .tinstValue   (tinstValue)
  );
endmodule

// File: rtl/tinst_gen_chk.sv
module tinst_gen_chk (
  input logic        clk,
  input logic        rstN,
  input logic        trapValid,
  input logic        isCompressed,
  input logic [2:0]  instrClass,
  input logic [5:0]  causeCode,
  input logic        implicitWalk,
  input logic        gpaNonzero,
  input logic        tinstValid,
  input logic [31:0] tinstValue
);
  logic faultCause, guestCause, classKnown;
  assign faultCause = causeCode inside {6'd4, 6'd5, 6'd6, 6'd7, 6'd13, 6'd15, 6'd21, 6'd23};
  assign guestCause = causeCode inside {6'd21, 6'd23};
  assign classKnown = (instrClass >= 3'd1) && (instrClass <= 3'd4);

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> tinstValid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |=> !tinstValid); // R1
  AST_VALUE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |=> $stable(tinstValue)); // R1
  AST_OTHER_CAUSE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && !faultCause) |=> (tinstValue == 32'd0)); // R2
  AST_FULL_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && faultCause && !implicitWalk && !isCompressed && classKnown)
      |=> (tinstValue[1:0] == 2'b11)); // R3
  AST_COMPRESSED_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && !implicitWalk && isCompressed)
      |=> (tinstValue == 32'd0 || tinstValue[1:0] == 2'b01)); // R6
  AST_PSEUDO_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && implicitWalk && guestCause && gpaNonzero)
      |=> (tinstValue != 32'd0 && tinstValue[1:0] == 2'b00)); // R9
  AST_WALK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && implicitWalk && !(guestCause && gpaNonzero))
      |=> (tinstValue == 32'd0)); // R10
endmodule

bind tinst_gen tinst_gen_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .trapValid    (trapValid),
  .isCompressed (isCompressed),
  .instrClass   (instrClass),
  .causeCode    (causeCode),
  .implicitWalk (implicitWalk),
  .gpaNonzero   (gpaNonzero),
  .tinstValid   (tinstValid),
  .tinstValue   (tinstValue)
);

// File: tb/test_tinst_gen.sv
module test_tinst_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapValid = 1'b0;
  logic [31:0] instrBits = '0;
  logic        isCompressed = 1'b0;
  logic [2:0]  instrClass = '0;
  logic [5:0]  causeCode = '0;
  logic        implicitWalk = 1'b0;
  logic        walkIs64 = 1'b0;
  logic        walkIsWrite = 1'b0;
  logic        gpaNonzero = 1'b0;
  logic        tinstValid;
  logic [31:0] tinstValue;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  tinst_gen i_tinst_gen (.*);

  always #2 clk = ~clk;

  function automatic logic [31:0] refVal(input logic [31:0] ins, input bit comp, input int cls,
      input int cause, input bit walk, input bit w64, input bit wr, input bit gpa,
      output string tag);
    int q, f, f3, r, op;
    bit st, fp;
    if (!(cause inside {4, 5, 6, 7, 13, 15, 21, 23})) begin tag = "R2"; return 32'd0; end
    if (walk) begin
      tag = (cls != 0 || comp) ? "R11" : "R10";
      if ((cause == 21 || cause == 23) && gpa) begin
        if (tag == "R10") tag = "R9";
        return 32'h2000 + (w64 ? 32'h1000 : 0) + (wr ? 32'h20 : 0);
      end
      return 32'd0;
    end
    if (cls == 0) begin tag = "R8"; return 32'd0; end
    if (comp) begin
      tag = "R8";
      if (cls > 2) return 32'd0;
      q = int'(ins[1:0]);
      f = int'(ins[15:13]);
      if ((q != 0 && q != 2) || f == 0 || f == 4) return 32'd0;
      st = (f >= 4);
      fp = (f % 4 == 1);
      f3 = (f % 4 == 2) ? 2 : 3;
      op = st ? (fp ? 'h27 : 'h23) : (fp ? 'h07 : 'h03);
      r  = (q == 0) ? 8 + int'(ins[4:2]) : (st ? int'(ins[6:2]) : int'(ins[11:7]));
      op = op - 2;
      if (st) begin tag = "R7"; return 32'((r << 20) + (f3 << 12) + op); end
      tag = "R6";
      return 32'((f3 << 12) + (r << 7) + op);
    end
    if (cls == 1) begin tag = "R3"; return (ins & 32'h0000_7FFF) | 32'h3; end
    if (cls == 2) begin tag = "R4"; return (ins & 32'h01F0_707F) | 32'h3; end
    tag = "R5";
    return (ins & ~32'h000F_8000) | 32'h3;
  endfunction

  logic [31:0] expValue;
  logic        expValid;
  string       expTag;

  always @(posedge clk) begin
    string t;
    logic [31:0] v;
    if (!rstN) begin
      expValid <= 1'b0; expValue <= '0; expTag <= "R1";
    end else begin
      expValid <= trapValid;
      if (trapValid) begin
        v = refVal(instrBits, isCompressed, int'(instrClass), int'(causeCode),
                   implicitWalk, walkIs64, walkIsWrite, gpaNonzero, t);
        expValue <= v; expTag <= t;
      end else expTag <= "R1";
    end
  end

  always @(negedge clk) begin
    if (running) begin
      checks++;
      if (tinstValid !== expValid) begin
        errors++;
        $display("FAIL R1 valid: actual %0b expected %0b", tinstValid, expValid);
      end
      checks++;
      if (tinstValue !== expValue) begin
        errors++;
        $display("FAIL %s value: actual %08h expected %08h", expTag, tinstValue, expValue);
      end
    end
  end

  task automatic trap(input logic [31:0] ins, input bit comp, input int cls, input int cause,
                      input bit walk, input bit w64, input bit wr, input bit gpa);
    @(negedge clk);
    trapValid = 1'b1; instrBits = ins; isCompressed = comp; instrClass = 3'(cls);
    causeCode = 6'(cause); implicitWalk = walk; walkIs64 = w64; walkIsWrite = wr;
    gpaNonzero = gpa;
    @(negedge clk);
    trapValid = 1'b0;
    instrBits = $urandom; causeCode = 6'($urandom);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1 reset state
    if (tinstValid !== 1'b0 || tinstValue !== 32'd0) begin
      errors++;
      $display("FAIL R1 reset: actual %0b/%08h expected 0/00000000", tinstValid, tinstValue);
    end
    rstN = 1'b1;
    @(negedge clk);
    running = 1'b1;
    // R3 R4 R5 full-size transforms
    trap(32'h0085_2283, 0, 1, 5, 0, 0, 0, 0);
    trap(32'h00B5_3423, 0, 2, 7, 0, 0, 0, 0);
    trap(32'h00B5_202F, 0, 3, 15, 0, 0, 0, 0);
    trap(32'h6805_C573, 0, 4, 21, 0, 0, 0, 0);
    // R6 R7 compressed, both quadrants
    trap(32'hFFFF_4188, 1, 1, 13, 0, 0, 0, 0);
    trap(32'h0000_2008, 1, 1, 4, 0, 0, 0, 0);
    trap(32'h0000_6108, 1, 1, 5, 0, 0, 0, 0);
    trap(32'h0000_4522, 1, 1, 21, 0, 0, 0, 0);
    trap(32'h0000_E406, 1, 2, 23, 0, 0, 0, 0);
    trap(32'h0000_C188, 1, 2, 6, 0, 0, 0, 0);
    trap(32'h0000_A02A, 1, 2, 15, 0, 0, 0, 0);
    // R8 zero cases
    trap(32'h0000_4501, 1, 1, 5, 0, 0, 0, 0);
    trap(32'h0000_8188, 1, 2, 7, 0, 0, 0, 0);
    trap(32'h0000_4188, 1, 3, 7, 0, 0, 0, 0);
    trap(32'h0085_2283, 0, 0, 5, 0, 0, 0, 0);
    // R2 uncovered causes
    trap(32'h0085_2283, 0, 1, 22, 0, 0, 0, 0);
    trap(32'h0085_2283, 0, 1, 2, 0, 0, 0, 0);
    trap(32'h0085_2283, 0, 1, 12, 1, 1, 1, 1);
    // R9 all four pseudo codes, R10, R11
    for (int k = 0; k < 4; k++) trap(32'h0, 0, 0, 21 + 2 * (k % 2), 1, k[1], k[0], 1);
    trap(32'h0085_2283, 0, 1, 21, 1, 1, 0, 1);
    trap(32'h0085_2283, 0, 1, 21, 1, 1, 0, 0);
    trap(32'h0, 0, 0, 13, 1, 0, 1, 1);
    // random mix with idle gaps
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ins = $urandom;
      bit comp = ($urandom % 3 == 0);
      int cls = $urandom % 5;
      int cause = ($urandom % 4 == 0) ? int'($urandom % 32)
                : int'(($urandom % 2) ? 21 + 2 * ($urandom % 2) : 4 + ($urandom % 4));
      if (!comp) ins[1:0] = 2'b11;
      else if (ins[1:0] == 2'b11) ins[1] = 1'b0;
      trap(ins, comp, cls, cause, ($urandom % 4 == 0), $urandom % 2, $urandom % 2, $urandom % 2);
      repeat ($urandom % 3) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    running = 1'b0;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule